// File: doc/BRIEF.md
# Parallel Flash Command Sequence Decoder

This block sits behind the write strobes of a parallel NOR-style flash bus. Each clock cycle with `wr_en` high is one bus write carrying an address and a data word. The block follows the multi-write unlock sequences a host uses to ask for identification reads, word programs, a fast-program bypass session, chip and multi-block erases, and erase suspend and resume. It reports the current device mode, drives an active-high ready flag that drops while an internal operation is running, and tells the read path which source to return. While the identification mode is active it also supplies the identification and protection codes.

Program, erase, the block-collection window and the abort are timed by parameterised down-counters. These stand in for the real array operations. Software uses the block the way it would use a real part: it issues unlock writes, polls `ready`, and reads the returned code or the array.

Top module: `flash_cmd_seq`

## Requirements
- R1: The `mode` output encodes 0 read array, 1 identification, 2 program, 3 bypass, 4 erase setup or block-collection window, 5 erasing, 6 erase suspended and 7 abort. After a synchronous reset `mode` is 0, `ready` is 1, `rd_src` is 0 and `erase_map` is all zeros.
- R2: In word mode (`byte_mode`=0) a command starts with data AA at address 555h and then data 55 at 2AAh. In byte mode the same address bits must match, and in addition `wr_addr_lsb` must be 0 on the 555h writes and 1 on the 2AAh write. The third write at 555h selects the command: 90 gives mode 1, A0 gives mode 2, 20 gives mode 3, 80 gives mode 4, and F0 gives mode 0.
- R3: A write that does not continue a valid sequence returns the decoder to its home mode: read array, or erase suspended during a suspend session.
- R4: Command matching compares only `wr_addr[10:0]`, the byte-mode low bit and `wr_data[7:0]`. All other address and data bits are ignored.
- R5: In mode 1, `rd_src` is 1 and `rd_code` depends on `rd_addr[1:0]`. The value 00 returns `MFR_ID`. The value 01 returns `DEV_ID`. The value 10 returns 1 if `prot_map` bit `rd_addr[15:12]` is set and 0 otherwise. The value 11 returns 0.
- R6: The write after A0 starts a program. `ready` stays low for exactly `T_PROG` cycles, and writes made during that time, including F0, are ignored.
- R7: In mode 3, a write of A0 followed by an address/data write performs a program, and the decoder then returns to mode 3. A write of 90 followed by 00 returns to mode 0.
- R8: After 80, a second AA/55 unlock pair and then 10 at 555h start a chip erase. In this state `erase_map` is all ones and the mode is 5 for exactly `T_ERASE` cycles. The decoder then returns to mode 0 with `erase_map` cleared. A block is `wr_addr[15:12]`.
- R9: In the same position, a write of 30 at any address marks that block and opens the collection window (mode 4, `ready` low). Each further 30 adds a block and restarts the window. When `T_WIN` cycles pass without a write, erasing starts (mode 5).
- R10: While erasing, B0 suspends (mode 6, `ready` high). A later 30 resumes, and the total time spent erasing still equals `T_ERASE`.
- R11: While suspended, a full program sequence to a block marked for erase is rejected: the mode stays 6 and `ready` stays high. A program to an unmarked block runs and then returns to mode 6.
- R12: Any of the following enters mode 7: F0 during the collection window, F0 while erasing, F0 while suspended, or any write other than 30 during the collection window. In mode 7 `ready` is low and `rd_src` is 3 for exactly `T_ABORT` cycles. The decoder then returns to mode 0 with `erase_map` cleared.
- R13: `rd_src` is 2 (status) while a program, the collection window or an erase is running. It is 0 (array) in read, bypass and suspended modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One bus write per cycle when high |
| wr_addr | input | ADDR_W | Write address (word address) |
| wr_addr_lsb | input | 1 | Extra low address bit used in byte mode |
| wr_data | input | DATA_W | Write data |
| byte_mode | input | 1 | 1 selects 8-bit bus addressing |
| rd_addr | input | ADDR_W | Read address for identification codes |
| prot_map | input | NBLK | Per-block protection flags |
| ready | output | 1 | High when no internal operation is running |
| mode | output | 3 | Current device mode code |
| rd_src | output | 2 | Read source: 0 array, 1 code, 2 status, 3 invalid |
| rd_code | output | DATA_W | Identification / protection code |
| erase_map | output | NBLK | Blocks marked for the current erase |

## Verification
The bench targets several corner cases, each paired with the fault it would expose:
- A repeated AA in place of the command byte. A decoder that restarts its prefix there would wrongly enter identification mode.
- A byte-mode write with the wrong low address bit. Accepting it would show that the byte-mode bit is never compared.
- Ready timing of program, erase, window and abort, sampled one cycle before and one cycle after the expected edge. An off-by-one counter load fails at one of the two samples.
- Suspend followed by resume. If the erase counter runs on during the suspend, erasing ends too early after the resume.
- A suspended program aimed at a marked block. If it is not rejected, `ready` drops.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    typedef enum logic [3:0] {
        ST_READ, ST_UNL1, ST_UNL2, ST_IDENT, ST_PGM_WAIT, ST_PGM_BUSY,
        ST_BYP, ST_BYP_PGM, ST_BYP_EXIT, ST_ERS_U0, ST_ERS_U1, ST_ERS_U2,
        ST_ERS_WIN, ST_ERASING, ST_SUSP, ST_ABORT
    } fcs_state_e;

    typedef struct packed {
        logic       at_cmd;   // address matches the 555h (word) command slot
        logic       at_unl2;  // address matches the 2AAh (word) unlock slot
        logic [7:0] op;       // command byte
    } fcs_evt_t;

    localparam logic [7:0] OP_UNLA   = 8'hAA;
    localparam logic [7:0] OP_UNLB   = 8'h55;
    localparam logic [7:0] OP_RESET  = 8'hF0;
    localparam logic [7:0] OP_IDENT  = 8'h90;
    localparam logic [7:0] OP_PGM    = 8'hA0;
    localparam logic [7:0] OP_BYPASS = 8'h20;
    localparam logic [7:0] OP_ERASE  = 8'h80;
    localparam logic [7:0] OP_CHIP   = 8'h10;
    localparam logic [7:0] OP_BLOCK  = 8'h30;
    localparam logic [7:0] OP_SUSP   = 8'hB0;
    localparam logic [7:0] OP_ZERO   = 8'h00;

    localparam logic [2:0] MD_READ  = 3'd0;
    localparam logic [2:0] MD_IDENT = 3'd1;
    localparam logic [2:0] MD_PGM   = 3'd2;
    localparam logic [2:0] MD_BYP   = 3'd3;
    localparam logic [2:0] MD_ESET  = 3'd4;
    localparam logic [2:0] MD_ERS   = 3'd5;
    localparam logic [2:0] MD_SUSP  = 3'd6;
    localparam logic [2:0] MD_ABORT = 3'd7;

    localparam logic [1:0] SRC_ARRAY  = 2'd0;
    localparam logic [1:0] SRC_CODE   = 2'd1;
    localparam logic [1:0] SRC_STATUS = 2'd2;
    localparam logic [1:0] SRC_NONE   = 2'd3;

    function automatic logic [2:0] mode_of(fcs_state_e s, logic susp);
        case (s)
            ST_READ:                          mode_of = MD_READ;
            ST_UNL1, ST_UNL2:                 mode_of = susp ? MD_SUSP : MD_READ;
            ST_IDENT:                         mode_of = MD_IDENT;
            ST_PGM_WAIT, ST_PGM_BUSY:         mode_of = MD_PGM;
            ST_BYP, ST_BYP_PGM, ST_BYP_EXIT:  mode_of = MD_BYP;
            ST_ERASING:                       mode_of = MD_ERS;
            ST_SUSP:                          mode_of = MD_SUSP;
            ST_ABORT:                         mode_of = MD_ABORT;
            default:                          mode_of = MD_ESET;
        endcase
    endfunction

    function automatic logic [1:0] src_of(fcs_state_e s);
        case (s)
            ST_IDENT:                            src_of = SRC_CODE;
            ST_PGM_BUSY, ST_ERS_WIN, ST_ERASING: src_of = SRC_STATUS;
            ST_ABORT:                            src_of = SRC_NONE;
            default:                             src_of = SRC_ARRAY;
        endcase
    endfunction

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/fcs_wr_decode.sv
module fcs_wr_decode
    import fcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int BLK_W  = 4
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              addr_lsb,
    input  logic              byte_mode,
    input  logic [DATA_W-1:0] data,
    output fcs_evt_t          evt,
    output logic [BLK_W-1:0]  blk
);
    logic [10:0] key;

    assign key = addr[10:0];
    assign blk = addr[ADDR_W-1 -: BLK_W];

    always_comb begin
        evt.op      = data[7:0];
        // In byte mode the extra low bit extends the key: 555h->AAAh, 2AAh->555h.
        evt.at_cmd  = (key == 11'h555) && (!byte_mode || !addr_lsb);
        evt.at_unl2 = (key == 11'h2AA) && (!byte_mode ||  addr_lsb);
    end
endmodule

// File: rtl/fcs_down_cnt.sv
module fcs_down_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         run,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (run && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/fcs_id_mux.sv
module fcs_id_mux #(
    parameter int                ADDR_W = 16,
    parameter int                DATA_W = 16,
    parameter int                BLK_W  = 4,
    parameter logic [DATA_W-1:0] MFR_ID = 16'h0020,
    parameter logic [DATA_W-1:0] DEV_ID = 16'h00D5
) (
    input  logic                  en,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic [(1<<BLK_W)-1:0] prot_map,
    output logic [DATA_W-1:0]     code
);
    logic [BLK_W-1:0] blk;

    assign blk = rd_addr[ADDR_W-1 -: BLK_W];

    always_comb begin
        code = '0;
        if (en) begin
            case (rd_addr[1:0])
                2'b00:   code = MFR_ID;
                2'b01:   code = DEV_ID;
                2'b10:   code = DATA_W'(prot_map[blk]);
                default: code = '0;
            endcase
        end
    end
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import fcs_pkg::*;
#(
    parameter int                ADDR_W  = 16,
    parameter int                DATA_W  = 16,
    parameter int                BLK_W   = 4,
    parameter int                T_PROG  = 400,
    parameter int                T_ERASE = 5000,
    parameter int                T_WIN   = 300,
    parameter int                T_ABORT = 100,
    parameter logic [DATA_W-1:0] MFR_ID  = 16'h0020,
    parameter logic [DATA_W-1:0] DEV_ID  = 16'h00D5
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic                  wr_addr_lsb,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic                  byte_mode,
    input  logic [ADDR_W-1:0]     rd_addr,
    input  logic [(1<<BLK_W)-1:0] prot_map,
    output logic                  ready,
    output logic [2:0]            mode,
    output logic [1:0]            rd_src,
    output logic [DATA_W-1:0]     rd_code,
    output logic [(1<<BLK_W)-1:0] erase_map
);
    localparam int NBLK   = 1 << BLK_W;
    localparam int OP_MAX = max3(T_PROG, T_WIN, T_ABORT);
    localparam int OP_W   = $clog2(OP_MAX + 1);
    localparam int ER_W   = $clog2(T_ERASE + 1);

    fcs_state_e       state_q, state_d, ret_q, ret_d, home;
    logic             susp_q, susp_d;
    logic [NBLK-1:0]  map_q, map_d, blk_bit;
    fcs_evt_t         evt;
    logic [BLK_W-1:0] blk;
    logic             op_load, op_zero, er_load, er_zero;
    logic [OP_W-1:0]  op_val;
    logic             first_unl;

    fcs_wr_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W)) u_dec (
        .addr(wr_addr), .addr_lsb(wr_addr_lsb), .byte_mode(byte_mode),
        .data(wr_data), .evt(evt), .blk(blk)
    );

    fcs_down_cnt #(.W(OP_W)) u_op_cnt (
        .clk(clk), .rst(rst), .load(op_load), .load_val(op_val),
        .run(1'b1), .zero(op_zero)
    );

    fcs_down_cnt #(.W(ER_W)) u_er_cnt (
        .clk(clk), .rst(rst), .load(er_load), .load_val(ER_W'(T_ERASE - 1)),
        .run(state_q == ST_ERASING), .zero(er_zero)
    );

    fcs_id_mux #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W),
        .MFR_ID(MFR_ID), .DEV_ID(DEV_ID)
    ) u_id (
        .en(state_q == ST_IDENT), .rd_addr(rd_addr), .prot_map(prot_map),
        .code(rd_code)
    );

    assign blk_bit   = NBLK'(1) << blk;
    assign home      = susp_q ? ST_SUSP : ST_READ;
    assign first_unl = evt.at_cmd && evt.op == OP_UNLA;

    always_comb begin
        state_d = state_q;
        ret_d   = ret_q;
        susp_d  = susp_q;
        map_d   = map_q;
        op_load = 1'b0;
        op_val  = '0;
        er_load = 1'b0;
        case (state_q)
            ST_READ: if (wr_en && first_unl) state_d = ST_UNL1;
            ST_UNL1: if (wr_en)
                state_d = (evt.at_unl2 && evt.op == OP_UNLB) ? ST_UNL2 : home;
            ST_UNL2: if (wr_en) begin
                state_d = home;
                if (evt.at_cmd) begin
                    case (evt.op)
                        OP_IDENT:  state_d = ST_IDENT;
                        OP_PGM:    state_d = ST_PGM_WAIT;
                        OP_BYPASS: if (!susp_q) state_d = ST_BYP;
                        OP_ERASE:  if (!susp_q) state_d = ST_ERS_U0;
                        default:   state_d = home;
                    endcase
                end
            end
            ST_IDENT: if (wr_en) begin
                if (evt.op == OP_RESET) state_d = home;
                else if (first_unl)     state_d = ST_UNL1;
            end
            ST_PGM_WAIT: if (wr_en) begin
                if (susp_q && map_q[blk]) begin
                    state_d = home;
                end else begin
                    state_d = ST_PGM_BUSY;
                    ret_d   = home;
                    op_load = 1'b1;
                    op_val  = OP_W'(T_PROG - 1);
                end
            end
            ST_PGM_BUSY: if (op_zero) state_d = ret_q;
            ST_BYP: if (wr_en) begin
                if (evt.op == OP_PGM)        state_d = ST_BYP_PGM;
                else if (evt.op == OP_IDENT) state_d = ST_BYP_EXIT;
            end
            ST_BYP_PGM: if (wr_en) begin
                state_d = ST_PGM_BUSY;
                ret_d   = ST_BYP;
                op_load = 1'b1;
                op_val  = OP_W'(T_PROG - 1);
            end
            ST_BYP_EXIT: if (wr_en) state_d = (evt.op == OP_ZERO) ? ST_READ : ST_BYP;
            ST_ERS_U0: if (wr_en) state_d = first_unl ? ST_ERS_U1 : ST_READ;
            ST_ERS_U1: if (wr_en)
                state_d = (evt.at_unl2 && evt.op == OP_UNLB) ? ST_ERS_U2 : ST_READ;
            ST_ERS_U2: if (wr_en) begin
                if (evt.at_cmd && evt.op == OP_CHIP) begin
                    map_d   = '1;
                    er_load = 1'b1;
                    state_d = ST_ERASING;
                end else if (evt.op == OP_BLOCK) begin
                    map_d   = blk_bit;
                    op_load = 1'b1;
                    op_val  = OP_W'(T_WIN - 1);
                    state_d = ST_ERS_WIN;
                end else begin
                    state_d = ST_READ;
                end
            end
            ST_ERS_WIN: begin
                if (wr_en && evt.op == OP_BLOCK) begin
                    map_d   = map_q | blk_bit;
                    op_load = 1'b1;
                    op_val  = OP_W'(T_WIN - 1);
                end else if (wr_en) begin
                    state_d = ST_ABORT;
                    op_load = 1'b1;
                    op_val  = OP_W'(T_ABORT - 1);
                end else if (op_zero) begin
                    er_load = 1'b1;
                    state_d = ST_ERASING;
                end
            end
            ST_ERASING: begin
                if (wr_en && evt.op == OP_SUSP) begin
                    state_d = ST_SUSP;
                    susp_d  = 1'b1;
                end else if (wr_en && evt.op == OP_RESET) begin
                    state_d = ST_ABORT;
                    op_load = 1'b1;
                    op_val  = OP_W'(T_ABORT - 1);
                end else if (er_zero) begin
                    state_d = ST_READ;
                    map_d   = '0;
                end
            end
            ST_SUSP: if (wr_en) begin
                if (evt.op == OP_BLOCK) begin
                    state_d = ST_ERASING;
                    susp_d  = 1'b0;
                end else if (evt.op == OP_RESET) begin
                    state_d = ST_ABORT;
                    susp_d  = 1'b0;
                    op_load = 1'b1;
                    op_val  = OP_W'(T_ABORT - 1);
                end else if (first_unl) begin
                    state_d = ST_UNL1;
                end
            end
            ST_ABORT: if (op_zero) begin
                state_d = ST_READ;
                map_d   = '0;
            end
            default: state_d = ST_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_READ;
            ret_q   <= ST_READ;
            susp_q  <= 1'b0;
            map_q   <= '0;
        end else begin
            state_q <= state_d;
            ret_q   <= ret_d;
            susp_q  <= susp_d;
            map_q   <= map_d;
        end
    end

    assign mode      = mode_of(state_q, susp_q);
    assign rd_src    = src_of(state_q);
    assign ready     = !(state_q inside {ST_PGM_BUSY, ST_ERS_WIN, ST_ERASING, ST_ABORT});
    assign erase_map = map_q;
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
    parameter int NBLK = 16
) (
    input logic            clk,
    input logic            rst,
    input logic            wr_en,
    input logic [7:0]      wr_op,
    input logic            ready,
    input logic [2:0]      mode,
    input logic [1:0]      rd_src,
    input logic [NBLK-1:0] erase_map
);
    assert_busy_modes_R6: assert property (@(posedge clk) disable iff (rst)
        !ready |-> (mode == 3'd2 || mode == 3'd4 || mode == 3'd5 || mode == 3'd7));

    assert_abort_view_R12: assert property (@(posedge clk) disable iff (rst)
        mode == 3'd7 |-> (!ready && rd_src == 2'd3));

    assert_abort_exit_R12: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == 3'd7 && mode != 3'd7) |-> (mode == 3'd0 && erase_map == '0));

    assert_susp_ready_R10: assert property (@(posedge clk) disable iff (rst)
        mode == 3'd6 |-> (ready && rd_src == 2'd0));

    assert_resume_cause_R10: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == 3'd6 && mode == 3'd5) |-> ($past(wr_en) && $past(wr_op) == 8'h30));

    assert_ident_src_R5: assert property (@(posedge clk) disable iff (rst)
        mode == 3'd1 |-> rd_src == 2'd1);

    assert_erase_done_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(mode) == 3'd5 && mode == 3'd0) |-> erase_map == '0);

    assert_map_by_write_R9: assert property (@(posedge clk) disable iff (rst)
        (erase_map != $past(erase_map) && erase_map != '0) |-> $past(wr_en));
endmodule

bind flash_cmd_seq fcs_checker #(.NBLK(NBLK)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_op(wr_data[7:0]),
    .ready(ready), .mode(mode), .rd_src(rd_src), .erase_map(erase_map)
);

// File: tb/flash_cmd_seq_tb.sv
`timescale 1ns/1ps
module flash_cmd_seq_tb;
    localparam int TP = 6, TE = 12, TW = 5, TA = 3;
    localparam logic [15:0] DEVC = 16'h00D5;
    localparam int NV = 25;
    // {addr, lsb, byte_mode, data, expected mode}
    localparam logic [36:0] VEC [NV] = '{
        {16'h0555, 1'b0, 1'b0, 16'h00AA, 3'd0},
        {16'h02AA, 1'b0, 1'b0, 16'h0055, 3'd0},
        {16'h0555, 1'b0, 1'b0, 16'h0090, 3'd1},
        {16'h0123, 1'b0, 1'b0, 16'h00F0, 3'd0},
        {16'h0555, 1'b0, 1'b0, 16'h00AA, 3'd0},
        {16'h02AA, 1'b0, 1'b0, 16'h0055, 3'd0},
        {16'h0555, 1'b0, 1'b0, 16'h0020, 3'd3},
        {16'h0000, 1'b0, 1'b0, 16'h0090, 3'd3},
        {16'h0000, 1'b0, 1'b0, 16'h0000, 3'd0},
        {16'h0555, 1'b0, 1'b0, 16'h00AA, 3'd0},
        {16'h02AA, 1'b0, 1'b0, 16'h0055, 3'd0},
        {16'h0555, 1'b0, 1'b0, 16'h00AA, 3'd0},
        {16'h02AA, 1'b0, 1'b0, 16'h0055, 3'd0},
        {16'h0555, 1'b0, 1'b0, 16'h0090, 3'd0},
        {16'h0555, 1'b0, 1'b1, 16'h00AA, 3'd0},
        {16'h02AA, 1'b1, 1'b1, 16'h0055, 3'd0},
        {16'h0555, 1'b0, 1'b1, 16'h0090, 3'd1},
        {16'h0000, 1'b0, 1'b1, 16'h00F0, 3'd0},
        {16'h0555, 1'b1, 1'b1, 16'h00AA, 3'd0},
        {16'h02AA, 1'b1, 1'b1, 16'h0055, 3'd0},
        {16'h0555, 1'b0, 1'b1, 16'h0090, 3'd0},
        {16'hF555, 1'b1, 1'b0, 16'h12AA, 3'd0},
        {16'h9AAA, 1'b0, 1'b0, 16'h3455, 3'd0},
        {16'h7D55, 1'b0, 1'b0, 16'h5690, 3'd1},
        {16'h0000, 1'b0, 1'b0, 16'h00F0, 3'd0}
    };

    logic        clk = 1'b0, rst = 1'b1, wr_en = 1'b0, wr_addr_lsb = 1'b0, byte_mode = 1'b0;
    logic [15:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
    logic [15:0] prot_map = 16'h0008;
    logic        ready;
    logic [2:0]  mode;
    logic [1:0]  rd_src;
    logic [15:0] rd_code, erase_map;
    int          n_run = 0, n_fail = 0;
    logic        done = 1'b0;

    always #2 clk = ~clk;

    flash_cmd_seq #(
        .T_PROG(TP), .T_ERASE(TE), .T_WIN(TW), .T_ABORT(TA), .DEV_ID(DEVC)
    ) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_addr_lsb(wr_addr_lsb), .wr_data(wr_data), .byte_mode(byte_mode),
        .rd_addr(rd_addr), .prot_map(prot_map), .ready(ready), .mode(mode),
        .rd_src(rd_src), .rd_code(rd_code), .erase_map(erase_map)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic l, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_addr_lsb = l; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(16'h0555, 1'b0, 16'h00AA);
        wr(16'h02AA, 1'b0, 16'h0055);
    endtask

    task automatic chip_erase();
        unlock(); wr(16'h0555, 1'b0, 16'h0080);
        unlock(); wr(16'h0555, 1'b0, 16'h0010);
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        chk("R1 mode", mode, 0); chk("R1 ready", ready, 1);
        chk("R1 src", rd_src, 0); chk("R1 map", erase_map, 0);

        // R2 R3 R4 R7 vector table
        for (int i = 0; i < NV; i++) begin
            byte_mode = VEC[i][19];
            wr(VEC[i][36:21], VEC[i][20], VEC[i][18:3]);
            chk($sformatf("R2/R3/R4/R7 vec %0d mode", i), mode, VEC[i][2:0]);
        end
        byte_mode = 1'b0;

        // R5 identification codes
        unlock(); wr(16'h0555, 1'b0, 16'h0090);
        rd_addr = 16'h0000; #1 chk("R5 src", rd_src, 1); chk("R5 mfr", rd_code, 16'h0020);
        rd_addr = 16'h0001; #1 chk("R5 dev", rd_code, DEVC);
        rd_addr = 16'h3002; #1 chk("R5 prot set", rd_code, 16'h0001);
        rd_addr = 16'h4002; #1 chk("R5 prot clear", rd_code, 16'h0000);
        rd_addr = 16'h0003; #1 chk("R5 reserved", rd_code, 16'h0000);
        tick(1);
        wr(16'h0000, 1'b0, 16'h00F0);
        chk("R2 reset from ident", mode, 0);

        // R6 program timing and F0 ignored while busy
        unlock(); wr(16'h0555, 1'b0, 16'h00A0);
        chk("R2 pgm mode", mode, 2); chk("R6 wait ready", ready, 1);
        wr(16'h1234, 1'b0, 16'hBEEF);
        chk("R6 busy", ready, 0); chk("R13 pgm src", rd_src, 2);
        tick(1);
        wr(16'h0000, 1'b0, 16'h00F0);
        chk("R6 F0 ignored", ready, 0);
        tick(TP - 3);
        chk("R6 last busy", ready, 0);
        tick(1);
        chk("R6 ready", ready, 1); chk("R6 mode", mode, 0);

        // R7 bypass program
        unlock(); wr(16'h0555, 1'b0, 16'h0020);
        wr(16'h0000, 1'b0, 16'h00A0);
        chk("R7 byp pgm wait", mode, 3);
        wr(16'h4000, 1'b0, 16'h1111);
        chk("R7 byp busy", ready, 0); chk("R7 byp mode", mode, 2);
        tick(TP);
        chk("R7 back to bypass", mode, 3); chk("R13 byp src", rd_src, 0);
        wr(16'h0000, 1'b0, 16'h0090); wr(16'h0000, 1'b0, 16'h0000);
        chk("R7 exit", mode, 0);

        // R8 chip erase
        unlock(); wr(16'h0555, 1'b0, 16'h0080);
        chk("R2 erase setup", mode, 4);
        unlock(); wr(16'h0555, 1'b0, 16'h0010);
        chk("R8 mode", mode, 5); chk("R8 map", erase_map, 16'hFFFF); chk("R8 busy", ready, 0);
        tick(TE - 1);
        chk("R8 last erase", mode, 5);
        tick(1);
        chk("R8 done", mode, 0); chk("R8 map clear", erase_map, 0);

        // R9 block collection, R10 suspend/resume, R11 suspended program
        unlock(); wr(16'h0555, 1'b0, 16'h0080); unlock();
        wr(16'h3000, 1'b0, 16'h0030);
        chk("R9 window", mode, 4); chk("R9 busy", ready, 0); chk("R9 map", erase_map, 16'h0008);
        wr(16'h7000, 1'b0, 16'h0030);
        chk("R9 map add", erase_map, 16'h0088);
        tick(TW - 1);
        chk("R9 window last", mode, 4);
        tick(1);
        chk("R9 erasing", mode, 5);
        wr(16'h0000, 1'b0, 16'h00B0);
        chk("R10 suspended", mode, 6); chk("R10 ready", ready, 1); chk("R13 susp src", rd_src, 0);
        unlock(); wr(16'h0555, 1'b0, 16'h00A0); wr(16'h3010, 1'b0, 16'hAAAA);
        chk("R11 reject mode", mode, 6); chk("R11 reject ready", ready, 1);
        unlock(); wr(16'h0555, 1'b0, 16'h00A0); wr(16'h1010, 1'b0, 16'h5555);
        chk("R11 pgm mode", mode, 2); chk("R11 pgm busy", ready, 0);
        tick(TP);
        chk("R11 back to suspend", mode, 6);
        wr(16'h0000, 1'b0, 16'h0030);
        chk("R10 resumed", mode, 5); chk("R10 busy", ready, 0);
        tick(TE - 2);
        chk("R10 remaining", mode, 5);
        tick(1);
        chk("R10 done", mode, 0); chk("R10 map clear", erase_map, 0);

        // R12 abort from erasing
        chip_erase();
        tick(2);
        wr(16'h0000, 1'b0, 16'h00F0);
        chk("R12 abort mode", mode, 7); chk("R12 busy", ready, 0); chk("R12 src", rd_src, 3);
        tick(TA - 1);
        chk("R12 abort last", mode, 7);
        tick(1);
        chk("R12 done", mode, 0); chk("R12 map clear", erase_map, 0);

        // R12 abort on stray write in window
        unlock(); wr(16'h0555, 1'b0, 16'h0080); unlock();
        wr(16'h2000, 1'b0, 16'h0030);
        wr(16'h0000, 1'b0, 16'h0055);
        chk("R12 window abort", mode, 7);
        tick(TA);
        chk("R12 window abort done", mode, 0);

        // R3 broken erase prefix
        unlock(); wr(16'h0555, 1'b0, 16'h0080);
        wr(16'h0555, 1'b0, 16'h0055);
        chk("R3 erase break", mode, 0);

        // R1 reset during erase
        chip_erase();
        rst = 1'b1; tick(1); rst = 1'b0; tick(1);
        chk("R1 reset mode", mode, 0); chk("R1 reset ready", ready, 1);
        chk("R1 reset map", erase_map, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule